// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps a small 8-bit accumulator CPU with a shared bus through its instruction cycle. A step counter walks through six T-states, T1 to T6. The counter's index is joined with the opcode in the upper nibble of the instruction register, and the result addresses an internal microcode ROM. The ROM returns a 13-bit control word that raises the register load strobes, the bus drive enables and the ALU subtract select for the current step.

The first three steps are the same for every opcode. They move the program counter to the memory address register, load the instruction register from memory, and increment the program counter. The steps after that depend on the opcode. A jump loads the program counter from the operand and then goes straight back to T1. A halt stops the step counter, and only a reset starts it again. The datapath registers, the ALU and the memory sit outside the block and read the control word directly.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is low and directly after it, t_state is 0 (T1), halted is 0 and ctrl_word holds the T1 fetch word 0x0A00.
- R2: t_state counts 0,1,2,3,4,5 and then returns to 0, one step per clock, and never goes above 5.
- R3: For every opcode, steps 0, 1 and 2 give 0x0A00 (PC drive + MAR load), 0x0180 (RAM drive + IR load) and 0x1000 (PC increment). Control bits from bit 12 down to bit 0: PC increment, PC drive, PC load, MAR load, RAM drive, IR drive-operand... IR load is bit 7 and IR operand drive is bit 6; the remaining bits are A load, A drive, B load, ALU drive, subtract, output load.
- R4: Opcode 0001 (load A) gives 0x0240, 0x0120 and 0x0000 at steps 3, 4 and 5. Opcode 0010 (load B) gives 0x0240, 0x0108 and 0x0000.
- R5: Opcode 0100 (add) gives 0x0240, 0x0108 and 0x0024 at steps 3, 4 and 5. Opcode 0101 (subtract) gives the same words except that step 5 is 0x0026, with the subtract bit set.
- R6: Opcode 1110 (output) gives 0x0011 at step 3 and 0x0000 at steps 4 and 5.
- R7: Opcode 1000 (jump) gives 0x0040 at step 3 and 0x0440 at step 4. The step after step 4 is step 0.
- R8: Opcode 1111 (halt) gives 0x0000 at step 3 with halted at 1. From then until reset, t_state stays at 3, halted stays at 1 and ctrl_word is 0, whatever the instruction input does.
- R9: Every other opcode gives 0x0000 at steps 3, 4 and 5.
- R10: In every step, at most one of the bus drive bits is high. These are PC drive, RAM drive, IR operand drive, A drive and ALU drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_word | input | 8 | Instruction register contents: opcode in [7:4], operand in [3:0] |
| ctrl_word | output | 13 | Control word for the current step |
| halted | output | 1 | High from the halt step until reset |
| t_state | output | 3 | Current step index, 0 for T1 through 5 for T6 |

## Verification
The assertions assume that the opcode does not change within an instruction after T2. On the chip this holds because the instruction register loads only at T2. The bench follows the same rule: it changes ir_word only at the start of an instruction's first step, and changes it only once while the block is halted, to show that a changing opcode does not restart the counter. The stimulus walks through every defined opcode, unused codes including 0000, a jump followed by another instruction, and a halt that is cleared by reset in the middle of a run.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int OPW   = 4,
  parameter int STW   = 3,
  parameter int NSTEP = 6,
  parameter int CWW   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*OPW-1:0] ir_word,
  output logic [CWW-1:0]   ctrl_word,
  output logic             halted,
  output logic [STW-1:0]   t_state
);
  localparam int AW    = OPW + STW;
  localparam int DEPTH = 1 << AW;
  localparam logic [STW-1:0] T_LAST = STW'(NSTEP - 1);
  localparam logic [STW-1:0] T_EXE1 = STW'(3);
  localparam logic [STW-1:0] T_EXE2 = STW'(4);

  localparam logic [OPW-1:0] OP_LDA = 4'b0001;
  localparam logic [OPW-1:0] OP_LDB = 4'b0010;
  localparam logic [OPW-1:0] OP_ADD = 4'b0100;
  localparam logic [OPW-1:0] OP_SUB = 4'b0101;
  localparam logic [OPW-1:0] OP_JMP = 4'b1000;
  localparam logic [OPW-1:0] OP_OUT = 4'b1110;
  localparam logic [OPW-1:0] OP_HLT = 4'b1111;

  localparam int B_PCI  = 12;
  localparam int B_PCO  = 11;
  localparam int B_PCL  = 10;
  localparam int B_MARI = 9;
  localparam int B_RAMO = 8;
  localparam int B_IRI  = 7;
  localparam int B_IRO  = 6;
  localparam int B_AI   = 5;
  localparam int B_AO   = 4;
  localparam int B_BI   = 3;
  localparam int B_ALUO = 2;
  localparam int B_SUB  = 1;
  localparam int B_OUTI = 0;

  function automatic logic [CWW-1:0] uword(input logic [OPW-1:0] op, input logic [STW-1:0] t);
    logic [CWW-1:0] w;
    w = '0;
    case (t)
      3'd0: begin w[B_PCO] = 1'b1; w[B_MARI] = 1'b1; end
      3'd1: begin w[B_RAMO] = 1'b1; w[B_IRI] = 1'b1; end
      3'd2: w[B_PCI] = 1'b1;
      3'd3: begin
        case (op)
          OP_LDA, OP_LDB, OP_ADD, OP_SUB: begin w[B_IRO] = 1'b1; w[B_MARI] = 1'b1; end
          OP_OUT: begin w[B_AO] = 1'b1; w[B_OUTI] = 1'b1; end
          OP_JMP: w[B_IRO] = 1'b1;
          default: w = '0;
        endcase
      end
      3'd4: begin
        case (op)
          OP_LDA: begin w[B_RAMO] = 1'b1; w[B_AI] = 1'b1; end
          OP_LDB, OP_ADD, OP_SUB: begin w[B_RAMO] = 1'b1; w[B_BI] = 1'b1; end
          OP_JMP: begin w[B_IRO] = 1'b1; w[B_PCL] = 1'b1; end
          default: w = '0;
        endcase
      end
      3'd5: begin
        case (op)
          OP_ADD: begin w[B_ALUO] = 1'b1; w[B_AI] = 1'b1; end
          OP_SUB: begin w[B_ALUO] = 1'b1; w[B_AI] = 1'b1; w[B_SUB] = 1'b1; end
          default: w = '0;
        endcase
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  logic [CWW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    localparam logic [AW-1:0] ADDR = AW'(a);
    assign rom[a] = uword(ADDR[AW-1:STW], ADDR[STW-1:0]);
  end

  logic [OPW-1:0] opcode;
  logic           unused_operand;
  logic           halt_q;
  logic           halt_now;
  logic           jmp_back;

  assign opcode         = ir_word[2*OPW-1:OPW];
  assign unused_operand = ^ir_word[OPW-1:0];
  assign halt_now       = !halt_q && (t_state == T_EXE1) && (opcode == OP_HLT);
  assign jmp_back       = (t_state == T_EXE2) && (opcode == OP_JMP);
  assign halted         = halt_q | halt_now;
  assign ctrl_word      = halt_q ? '0 : rom[{opcode, t_state}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_state <= '0;
      halt_q  <= 1'b0;
    end else if (halted) begin
      halt_q  <= 1'b1;
    end else if (jmp_back || t_state == T_LAST) begin
      t_state <= '0;
    end else begin
      t_state <= t_state + 1'b1;
    end
  end

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n) t_state <= T_LAST);

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state == T_LAST && !halted) |=> t_state == '0);

  // R7
  jmp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state == T_EXE2 && opcode == OP_JMP && !halted) |=> t_state == '0);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(t_state) && ctrl_word == '0));

  // R10
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_word[B_PCO], ctrl_word[B_RAMO], ctrl_word[B_IRO],
                ctrl_word[B_AO], ctrl_word[B_ALUO]}) <= 1);
endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ir_word = 8'h00;
  logic [12:0] ctrl_word;
  logic        halted;
  logic [2:0]  t_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          req;
    logic [2:0]  st;
    logic [12:0] cw;
    logic        hl;
  } item_t;
  item_t sb[$];

  ucode_sequencer dut (.clk(clk), .rst_n(rst_n), .ir_word(ir_word),
                       .ctrl_word(ctrl_word), .halted(halted), .t_state(t_state));

  always #5 clk = ~clk;

  // Expected words taken from R3..R9
  function automatic logic [12:0] spec_word(input logic [3:0] op, input int t);
    if (t == 0) return 13'h0A00;
    if (t == 1) return 13'h0180;
    if (t == 2) return 13'h1000;
    case (op)
      4'b0001: return (t == 3) ? 13'h0240 : (t == 4) ? 13'h0120 : 13'h0000;
      4'b0010: return (t == 3) ? 13'h0240 : (t == 4) ? 13'h0108 : 13'h0000;
      4'b0100: return (t == 3) ? 13'h0240 : (t == 4) ? 13'h0108 : 13'h0024;
      4'b0101: return (t == 3) ? 13'h0240 : (t == 4) ? 13'h0108 : 13'h0026;
      4'b1110: return (t == 3) ? 13'h0011 : 13'h0000;
      4'b1000: return (t == 3) ? 13'h0040 : 13'h0440;
      default: return 13'h0000;
    endcase
  endfunction

  function automatic int spec_req(input logic [3:0] op, input int t);
    if (t < 3) return 3;
    case (op)
      4'b0001, 4'b0010: return 4;
      4'b0100, 4'b0101: return 5;
      4'b1110: return 6;
      4'b1000: return 7;
      4'b1111: return 8;
      default: return 9;
    endcase
  endfunction

  task automatic push_cycle(input int req, input logic [2:0] st, input logic [12:0] cw, input logic hl);
    item_t it;
    #2;
    it.req = req; it.st = st; it.cw = cw; it.hl = hl;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [3:0] op, input logic [3:0] operand);
    int last;
    ir_word = {op, operand};
    last = (op == 4'b1000) ? 4 : (op == 4'b1111) ? 3 : 5;
    for (int t = 0; t <= last; t++)
      push_cycle(spec_req(op, t), 3'(t), spec_word(op, t), (op == 4'b1111 && t == 3));
  endtask

  // R10: bus drive bits are 11, 8, 6, 4, 2
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t e;
        int drv;
        e = sb.pop_front();
        checks++;
        if (t_state !== e.st || ctrl_word !== e.cw || halted !== e.hl) begin
          errors++;
          $display("FAIL R%0d: step=%0d cw=%h halt=%b expected step=%0d cw=%h halt=%b",
                   e.req, t_state, ctrl_word, halted, e.st, e.cw, e.hl);
        end
        drv = int'(ctrl_word[11]) + int'(ctrl_word[8]) + int'(ctrl_word[6])
            + int'(ctrl_word[4]) + int'(ctrl_word[2]);
        checks++;
        if (drv > 1) begin
          errors++;
          $display("FAIL R10: drivers=%0d cw=%h expected at most 1", drv, ctrl_word);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 during reset
    push_cycle(1, 3'd0, 13'h0A00, 1'b0);
    push_cycle(1, 3'd0, 13'h0A00, 1'b0);
    rst_n = 1'b1;
    // R2 R4 R5 R6 R9 straight-line program
    run_instr(4'b0001, 4'h9);
    run_instr(4'b0010, 4'hA);
    run_instr(4'b0100, 4'h9);
    run_instr(4'b0101, 4'hA);
    run_instr(4'b1110, 4'h0);
    run_instr(4'b0011, 4'h5);
    run_instr(4'b0000, 4'h0);
    // R7 jump then the next instruction starts at step 0
    run_instr(4'b1000, 4'h2);
    run_instr(4'b0001, 4'h3);
    run_instr(4'b1000, 4'hF);
    run_instr(4'b0101, 4'h1);
    // R8 halt, then a new opcode on the input must not restart anything
    run_instr(4'b1111, 4'h0);
    ir_word = 8'h1C;
    for (int k = 0; k < 5; k++) push_cycle(8, 3'd3, 13'h0000, 1'b1);
    // R1 reset clears the halt
    rst_n = 1'b0;
    push_cycle(1, 3'd0, 13'h0A00, 1'b0);
    rst_n = 1'b1;
    run_instr(4'b0100, 4'h7);
    run_instr(4'b1100, 4'h4);
    run_instr(4'b0110, 4'h4);
    run_instr(4'b1110, 4'h0);
    run_instr(4'b1111, 4'h0);
    push_cycle(8, 3'd3, 13'h0000, 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule